// File: doc/BRIEF.md
# Clock Switch Acknowledge Watchdog

This block supervises the handshake that moves a chip's clock from its internal source to an external one, typically so that fuses can be programmed against a stable reference. A switch may be requested from a debug path or from a bus path. Either request makes the block raise a single switch request toward the system, which must answer with an acknowledge within a fixed window of internal clock cycles.

While it waits, the block counts internal cycles. An acknowledge inside the window sets a switched flag, which holds until both requesters let go. If no acknowledge arrives in time, the block drops its request and raises a program error. That error is fatal and sticky. Only a reset clears it, and the whole sequence must then be repeated. The clock multiplexer itself and the debug and bus front ends sit outside this block.

Top module: `clk_switch_ack_wd`

## Requirements
- R1: During and directly after reset, `sysSwitchReq`, `clkSwitched` and `progError` are all low.
- R2: When `dbgSwitchReq` or `busSwitchReq` is high at a rising edge while the block is idle and error-free, `sysSwitchReq` is high after that edge.
- R3: The two request inputs share one outstanding request. Both high together, or either one alone, gives the same single `sysSwitchReq`. The request stays up while at least one of them is held.
- R4: An acknowledge (`sysSwitchAck` high) sampled at the first or second rising edge after `sysSwitchReq` rose sets `clkSwitched` at that edge and leaves `progError` low. An acknowledge at the second edge, the last one allowed, takes priority over the timeout.
- R5: Once switched, `clkSwitched` and `sysSwitchReq` stay high regardless of the acknowledge level while any request is held. Both go low at the first edge at which both request inputs are low.
- R6: If no acknowledge is sampled at either of the `ACK_WINDOW` (default 2) edges after `sysSwitchReq` rose, `progError` goes high at the last of those edges and `sysSwitchReq` goes low there.
- R7: `progError` stays high until reset. After a reset, a fresh handshake completes normally.
- R8: While `progError` is high, requests are ignored: `sysSwitchReq` and `clkSwitched` stay low.
- R9: An acknowledge with no request outstanding changes no output. It also does not count toward a later request.
- R10: If both request inputs drop while the acknowledge is still awaited, the block returns to idle with `sysSwitchReq` low and no error. Withdrawal takes priority over an acknowledge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dbgSwitchReq | input | 1 | Switch request from the debug path |
| busSwitchReq | input | 1 | Switch request from the bus path |
| sysSwitchAck | input | 1 | Acknowledge returned by the system |
| sysSwitchReq | output | 1 | Clock-switch request toward the system |
| clkSwitched | output | 1 | Switch acknowledged in time and still requested |
| progError | output | 1 | Sticky program error after a missed deadline |

## Verification
Two events can collide on the last edge of the window: an acknowledge arriving and the deadline expiring. The bench holds the acknowledge low through the first edge and raises it just before the second. It then requires `clkSwitched` high and `progError` low, which shows the acknowledge winning. A second collision is between request withdrawal and the pending wait. The bench drops both requests inside the window and requires a clean return to idle, with no error over the following cycles.

// File: rtl/clk_switch_ack_wd_pkg.sv
package clk_switch_ack_wd_pkg;

  typedef enum logic [1:0] {
    StIdle  = 2'd0,
    StWait  = 2'd1,
    StDone  = 2'd2,
    StFault = 2'd3
  } swState_e;

  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic errSet;
  } dpStrobe_t;

endpackage

// File: rtl/clk_switch_ack_wd_dp.sv
module clk_switch_ack_wd_dp
  import clk_switch_ack_wd_pkg::*;
#(
  parameter int ACK_WINDOW = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  output logic      cntExpired,
  output logic      errFlag
);
  localparam int CNT_W = (ACK_WINDOW < 2) ? 1 : $clog2(ACK_WINDOW + 1);
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(ACK_WINDOW - 1);

  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobe.cntClear) begin
      waitCnt <= '0;
    end else if (strobe.cntStep) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (strobe.errSet) begin
      errFlag <= 1'b1;
    end
  end

  assign cntExpired = (waitCnt == LAST_WAIT);
endmodule

// File: rtl/clk_switch_ack_wd_ctrl.sv
module clk_switch_ack_wd_ctrl
  import clk_switch_ack_wd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      anyReq,
  input  logic      ackIn,
  input  logic      cntExpired,
  output dpStrobe_t strobe,
  output logic      reqOut,
  output logic      switchedOut
);
  swState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= StIdle;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      StIdle: begin
        if (anyReq) begin
          stateNext       = StWait;
          strobe.cntClear = 1'b1;
        end
      end
      StWait: begin
        if (!anyReq) begin
          stateNext = StIdle;
        end else if (ackIn) begin
          stateNext = StDone;
        end else if (cntExpired) begin
          stateNext     = StFault;
          strobe.errSet = 1'b1;
        end else begin
          strobe.cntStep = 1'b1;
        end
      end
      StDone: begin
        if (!anyReq) stateNext = StIdle;
      end
      StFault: stateNext = StFault;
      default: stateNext = StIdle;
    endcase
  end

  assign reqOut      = (state == StWait) || (state == StDone);
  assign switchedOut = (state == StDone);
endmodule

// File: rtl/clk_switch_ack_wd.sv
module clk_switch_ack_wd
  import clk_switch_ack_wd_pkg::*;
#(
  parameter int ACK_WINDOW = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dbgSwitchReq,
  input  logic busSwitchReq,
  input  logic sysSwitchAck,
  output logic sysSwitchReq,
  output logic clkSwitched,
  output logic progError
);
  dpStrobe_t strobe;
  logic      cntExpired;
  logic      anyReq;

  assign anyReq = dbgSwitchReq | busSwitchReq;

  clk_switch_ack_wd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .anyReq     (anyReq),
    .ackIn      (sysSwitchAck),
    .cntExpired (cntExpired),
    .strobe     (strobe),
    .reqOut     (sysSwitchReq),
    .switchedOut(clkSwitched)
  );

  clk_switch_ack_wd_dp #(.ACK_WINDOW(ACK_WINDOW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cntExpired(cntExpired),
    .errFlag   (progError)
  );
endmodule

// File: rtl/clk_switch_ack_wd_chk.sv
module clk_switch_ack_wd_chk #(
  parameter int ACK_WINDOW = 2
) (
  input logic clk,
  input logic rstN,
  input logic dbgSwitchReq,
  input logic busSwitchReq,
  input logic sysSwitchAck,
  input logic sysSwitchReq,
  input logic clkSwitched,
  input logic progError
);
  localparam int W = $clog2(ACK_WINDOW + 2) + 1;
  logic [W-1:0] pendCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendCnt <= '0;
    else if (sysSwitchReq && !clkSwitched) pendCnt <= pendCnt + 1'b1;
    else pendCnt <= '0;
  end

  a_r2_req_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysSwitchReq) |-> $past(dbgSwitchReq || busSwitchReq));

  a_r5_switched_has_req: assert property (@(posedge clk) disable iff (!rstN)
    clkSwitched |-> sysSwitchReq);

  a_r6_wait_bounded: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= W'(ACK_WINDOW));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    progError |=> progError);

  a_r8_quiet_in_err: assert property (@(posedge clk) disable iff (!rstN)
    progError |-> (!sysSwitchReq && !clkSwitched));

  a_r9_stray_ack: assert property (@(posedge clk) disable iff (!rstN)
    (sysSwitchAck && !sysSwitchReq && !dbgSwitchReq && !busSwitchReq)
      |=> (!sysSwitchReq && !clkSwitched));
endmodule

bind clk_switch_ack_wd clk_switch_ack_wd_chk #(.ACK_WINDOW(ACK_WINDOW)) u_chk (
  .clk(clk), .rstN(rstN), .dbgSwitchReq(dbgSwitchReq), .busSwitchReq(busSwitchReq),
  .sysSwitchAck(sysSwitchAck), .sysSwitchReq(sysSwitchReq),
  .clkSwitched(clkSwitched), .progError(progError)
);

// File: tb/sim_clk_switch_ack_wd.sv
`timescale 1ns/1ps
module sim_clk_switch_ack_wd;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dbgReq = 1'b0, busReq = 1'b0, ack = 1'b0;
  logic reqO, swO, errO;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clk_switch_ack_wd u0 (
    .clk(clk), .rstN(rstN), .dbgSwitchReq(dbgReq), .busSwitchReq(busReq),
    .sysSwitchAck(ack), .sysSwitchReq(reqO), .clkSwitched(swO), .progError(errO)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; dbgReq = 0; busReq = 0; ack = 0;
    step();
    check("R1 req in reset", reqO, 1'b0);
    check("R1 switched in reset", swO, 1'b0);
    check("R1 err in reset", errO, 1'b0);
    rstN = 1'b1;
    step();
    check("R1 req after reset", reqO, 1'b0);
    check("R1 err after reset", errO, 1'b0);
  endtask

  task automatic tAckFirst();
    dbgReq = 1; step();
    check("R2 debug raises req", reqO, 1'b1);
    check("R2 not yet switched", swO, 1'b0);
    ack = 1; step();
    check("R4 ack at first edge switched", swO, 1'b1);
    check("R4 no error", errO, 1'b0);
    ack = 0; step(); step();
    check("R5 switched held", swO, 1'b1);
    check("R5 req held", reqO, 1'b1);
    dbgReq = 0; step();
    check("R5 switched drops", swO, 1'b0);
    check("R5 req drops", reqO, 1'b0);
  endtask

  task automatic tAckLast();
    busReq = 1; step();
    check("R2 bus raises req", reqO, 1'b1);
    step();
    check("R4 still waiting", reqO, 1'b1);
    check("R4 no error yet", errO, 1'b0);
    ack = 1; step();
    check("R4 ack at last edge wins", swO, 1'b1);
    check("R4 last edge no error", errO, 1'b0);
    busReq = 0; ack = 0; step();
    check("R5 released", reqO, 1'b0);
  endtask

  task automatic tLate();
    busReq = 1; step(); step();
    check("R6 no error before deadline", errO, 1'b0);
    step();
    check("R6 error at deadline", errO, 1'b1);
    check("R6 req dropped", reqO, 1'b0);
    ack = 1; step();
    check("R7 late ack keeps error", errO, 1'b1);
    check("R7 late ack not switched", swO, 1'b0);
    ack = 0; busReq = 0; step();
    dbgReq = 1; step(); step();
    check("R8 req ignored in error", reqO, 1'b0);
    check("R7 error sticky", errO, 1'b1);
    dbgReq = 0;
  endtask

  task automatic tRecover();
    doReset();
    check("R7 reset clears error", errO, 1'b0);
    dbgReq = 1; step(); ack = 1; step();
    check("R7 handshake after reset", swO, 1'b1);
    dbgReq = 0; ack = 0; step();
  endtask

  task automatic tStrayAck();
    ack = 1; step(); step();
    check("R9 stray ack req", reqO, 1'b0);
    check("R9 stray ack switched", swO, 1'b0);
    check("R9 stray ack err", errO, 1'b0);
    ack = 0; busReq = 1; step(); step(); step();
    check("R9 stray ack not remembered", errO, 1'b1);
    check("R9 stray ack not switched", swO, 1'b0);
  endtask

  task automatic tAbort();
    busReq = 1; step();
    busReq = 0; ack = 1; step();
    check("R10 abort req low", reqO, 1'b0);
    check("R10 withdraw beats ack", swO, 1'b0);
    ack = 0; step(); step(); step();
    check("R10 no error after abort", errO, 1'b0);
  endtask

  task automatic tBoth();
    dbgReq = 1; busReq = 1; step();
    check("R3 both give req", reqO, 1'b1);
    ack = 1; step();
    check("R3 both switched", swO, 1'b1);
    ack = 0; dbgReq = 0; step();
    check("R3 bus alone holds", swO, 1'b1);
    busReq = 0; step();
    check("R3 release", reqO, 1'b0);
  endtask

  initial begin
    doReset();
    tAckFirst();
    tAckLast();
    tBoth();
    tAbort();
    tLate();
    tRecover();
    tStrayAck();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule